// File: doc/BRIEF.md
# Double-Buffered Memory-to-Memory DMA Channel

This block is one memory-to-memory copy channel with two descriptor slots. Each slot has its own source address, destination address and byte count. Software can fill the second slot while the first one is still copying, so that transfers run back to back with no gap. Each word is copied in two steps: a read from the source on a simple request/acknowledge memory port, then a write of the same word to the destination.

Software sees two state machines through the status register. The buffer tracker shows how many slots are loaded. The control machine shows what the data mover is doing. Two interrupt sources are reported. The next-free-buffer interrupt fires when a slot finishes while the other slot takes over. The done interrupt fires when the last loaded slot has finished and the mover is parked in stall.

A new transfer can start in two ways. Setting enable with a slot queued starts it. For plain memory copies, a start trigger kicks off a slot that was loaded after the channel went idle.

Top module: `m2m_dma_chan`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0, the interrupt register (0x04) reads 0, irq_o is low and mem_req_o is low.
- R2: Status bits [3:1] give the control machine: 0 idle, 1 stall, 2 memory read, 3 memory write; code 4 is reserved and never produced. Bits [5:4] give the buffer tracker: 0 none loaded, 1 one loaded, 2 both loaded. Bit 6 is the done flag.
- R3: A write to a byte-count register (slot 0 at 0x10, slot 1 at 0x14) loads that slot only if the slot is free and the count is at least 4. Bits [1:0] of the count are dropped. A write with a count below 4 has no effect, and so does a write to a slot that is occupied.
- R4: When no slot is loaded, the first slot to be loaded becomes the active one. A slot loaded after it runs next.
- R5: A control write (offset 0x00) that raises enable (bit 0) while a slot is loaded drives the first read request two clock edges after the write edge.
- R6: For each word, the channel reads the source address and then writes that data to the destination address. Both addresses advance by 4 per word. Source and destination writes (slot 0 at 0x18/0x1C, slot 1 at 0x20/0x24) have bits [1:0] forced to 0.
- R7: When a slot finishes while the other slot is loaded, copying goes straight on with the other slot, and next-free-buffer (interrupt bit 2) is set.
- R8: When the last loaded slot finishes, done (interrupt bit 1 and status bit 6) is set, the control machine enters stall and the buffer tracker shows none. Done is never set while a read or write is pending.
- R9: With enable already set and the channel stalled, a loaded slot waits until start (control bit 1) is written with enable. A trigger that arrives while no slot is loaded is held until a slot is loaded.
- R10: Writing 0 to an interrupt bit clears it. Writing 1 leaves it unchanged.
- R11: irq_o is high when done is set with its enable (control bit 2), or when next-free-buffer is set with its enable (control bit 21).
- R12: Writing enable low drops mem_req_o on the next cycle. On the following edge both machines read idle and none. Any queued slot is discarded, and its count reads 0.
- R13: A byte-count register reads the bytes still to copy in that slot, which is 0 once the slot has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access completes this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ack_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the done flag only rises with the mover in stall and no request pending;
- next-free-buffer only rises as the mover turns to a fresh read;
- every acknowledged read is followed by a write;
- requests are word aligned and only made while enabled;
- dropping enable empties both slots and parks the mover in idle;
- the reserved control code and an impossible buffer code never appear.

Other behaviours need the bench's scenarios to show them:
- the copied memory contents;
- the order in which the slots run and the order of the two interrupts;
- the rules for holding a trigger and for ignoring loads;
- the status words at each phase.

The bench covers these with a sweep over all pairs of short slot lengths.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    CTL_IDLE  = 3'd0,
    CTL_STALL = 3'd1,
    CTL_MEMRD = 3'd2,
    CTL_MEMWR = 3'd3,
    CTL_BWC   = 3'd4
  } ctl_state_e;

  typedef enum logic [1:0] {
    BUF_NONE = 2'd0,
    BUF_ONE  = 2'd1,
    BUF_TWO  = 2'd2
  } buf_state_e;

  localparam int REG_DW   = 32;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_INT  = 'h04;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_CNT  = 'h10;  // slot s at OFF_CNT + 4*s
  localparam int OFF_ADR  = 'h18;  // slot s: src at +8*s, dst at +8*s+4

  localparam int B_EN      = 0;
  localparam int B_START   = 1;
  localparam int B_DONE_IE = 2;
  localparam int B_NFB_IE  = 21;
  localparam int B_I_DONE  = 1;
  localparam int B_I_NFB   = 2;
endpackage

// File: rtl/dmac_slot.sv
module dmac_slot #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_src_i,
  input  logic              wr_dst_i,
  input  logic              wr_cnt_i,
  input  logic [ADDR_W-1:0] adr_wdata_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              beat_i,
  output logic              load_ok_o,
  output logic              valid_o,
  output logic              last_beat_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int AL = $clog2(WORD_BYTES);

  logic              valid_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;

  assign load_ok_o   = wr_cnt_i && !valid_q && (|cnt_wdata_i[CNT_W-1:AL]);
  assign last_beat_o = (cnt_q == CNT_W'(WORD_BYTES));
  assign valid_o     = valid_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_src_i && !valid_q) src_q <= {adr_wdata_i[ADDR_W-1:AL], {AL{1'b0}}};
      if (wr_dst_i && !valid_q) dst_q <= {adr_wdata_i[ADDR_W-1:AL], {AL{1'b0}}};
      if (load_ok_o) begin
        cnt_q   <= {cnt_wdata_i[CNT_W-1:AL], {AL{1'b0}}};
        valid_q <= 1'b1;
      end else if (beat_i && valid_q) begin
        src_q <= src_q + ADDR_W'(WORD_BYTES);
        dst_q <= dst_q + ADDR_W'(WORD_BYTES);
        cnt_q <= cnt_q - CNT_W'(WORD_BYTES);
        if (last_beat_o) valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine import dmac_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              go_i,
  input  logic              cur_valid_i,
  input  logic              cur_last_i,
  input  logic              other_valid_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output ctl_state_e        ctl_o,
  output logic              start_o,
  output logic              beat_o,
  output logic              nfb_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  ctl_state_e        ctl_q, ctl_d;
  logic              cap;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    ctl_d   = ctl_q;
    start_o = 1'b0;
    beat_o  = 1'b0;
    nfb_o   = 1'b0;
    done_o  = 1'b0;
    cap     = 1'b0;
    unique case (ctl_q)
      CTL_IDLE: if (en_i) ctl_d = CTL_STALL;
      CTL_STALL: begin
        if (!en_i) ctl_d = CTL_IDLE;
        else if (go_i && cur_valid_i) begin
          ctl_d   = CTL_MEMRD;
          start_o = 1'b1;
        end
      end
      CTL_MEMRD: begin
        if (!en_i) ctl_d = CTL_IDLE;
        else if (mem_ack_i) begin
          cap   = 1'b1;
          ctl_d = CTL_MEMWR;
        end
      end
      CTL_MEMWR: begin
        if (!en_i) ctl_d = CTL_IDLE;
        else if (mem_ack_i) begin
          beat_o = 1'b1;
          if (!cur_last_i) ctl_d = CTL_MEMRD;
          else if (other_valid_i) begin
            nfb_o = 1'b1;
            ctl_d = CTL_MEMRD;
          end else begin
            done_o = 1'b1;
            ctl_d  = CTL_STALL;
          end
        end
      end
      default: ctl_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_IDLE;
      data_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (cap) data_q <= mem_rdata_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign data_o = data_q;
endmodule

// File: rtl/m2m_dma_chan.sv
module m2m_dma_chan import dmac_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int NSLOT      = 2;

  logic en_q, die_q, nie_q, go_q, done_q, nfb_q, cur_q;
  logic ctrl_wr, int_wr, flush;
  logic eng_start, eng_beat, eng_nfb, eng_done, slot_done;
  ctl_state_e ctl;
  buf_state_e buf_st;
  logic [DATA_W-1:0] eng_data;

  logic [ADDR_W-1:0] src_s [NSLOT];
  logic [ADDR_W-1:0] dst_s [NSLOT];
  logic [CNT_W-1:0]  cnt_s [NSLOT];
  logic [NSLOT-1:0]  valid_s, last_s, load_ok_s;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == REG_AW'(OFF_CTRL));
  assign int_wr  = reg_wr_i && (reg_addr_i == REG_AW'(OFF_INT));
  assign flush   = ctrl_wr && !reg_wdata_i[B_EN] && en_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic wr_src, wr_dst, wr_cnt, beat;
    assign wr_cnt = reg_wr_i && (reg_addr_i == REG_AW'(OFF_CNT + 4*s));
    assign wr_src = reg_wr_i && (reg_addr_i == REG_AW'(OFF_ADR + 8*s));
    assign wr_dst = reg_wr_i && (reg_addr_i == REG_AW'(OFF_ADR + 8*s + 4));
    assign beat   = eng_beat && (cur_q == 1'(s));

    dmac_slot #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .WORD_BYTES(WORD_BYTES)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush),
      .wr_src_i   (wr_src),
      .wr_dst_i   (wr_dst),
      .wr_cnt_i   (wr_cnt),
      .adr_wdata_i(reg_wdata_i[ADDR_W-1:0]),
      .cnt_wdata_i(reg_wdata_i[CNT_W-1:0]),
      .beat_i     (beat),
      .load_ok_o  (load_ok_s[s]),
      .valid_o    (valid_s[s]),
      .last_beat_o(last_s[s]),
      .src_o      (src_s[s]),
      .dst_o      (dst_s[s]),
      .cnt_o      (cnt_s[s])
    );
  end

  dmac_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_q),
    .go_i         (go_q),
    .cur_valid_i  (valid_s[cur_q]),
    .cur_last_i   (last_s[cur_q]),
    .other_valid_i(valid_s[~cur_q]),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .ctl_o        (ctl),
    .start_o      (eng_start),
    .beat_o       (eng_beat),
    .nfb_o        (eng_nfb),
    .done_o       (eng_done),
    .data_o       (eng_data)
  );

  assign slot_done = eng_beat && last_s[cur_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      die_q  <= 1'b0;
      nie_q  <= 1'b0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      nfb_q  <= 1'b0;
      cur_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata_i[B_EN];
        die_q <= reg_wdata_i[B_DONE_IE];
        nie_q <= reg_wdata_i[B_NFB_IE];
      end
      // trigger: enable rising, or start written with enable
      if (flush) go_q <= 1'b0;
      else if (ctrl_wr && reg_wdata_i[B_EN] && (!en_q || reg_wdata_i[B_START])) go_q <= 1'b1;
      else if (eng_start) go_q <= 1'b0;

      if (eng_done) done_q <= 1'b1;
      else if (int_wr && !reg_wdata_i[B_I_DONE]) done_q <= 1'b0;
      if (eng_nfb) nfb_q <= 1'b1;
      else if (int_wr && !reg_wdata_i[B_I_NFB]) nfb_q <= 1'b0;

      if (flush) cur_q <= 1'b0;
      else if (valid_s == '0 && (|load_ok_s)) cur_q <= load_ok_s[1];
      else if (slot_done) cur_q <= ~cur_q;
    end
  end

  always_comb begin
    unique case (valid_s)
      2'b00:   buf_st = BUF_NONE;
      2'b11:   buf_st = BUF_TWO;
      default: buf_st = BUF_ONE;
    endcase
  end

  assign mem_req_o   = en_q && (ctl == CTL_MEMRD || ctl == CTL_MEMWR);
  assign mem_we_o    = (ctl == CTL_MEMWR);
  assign mem_addr_o  = mem_we_o ? dst_s[cur_q] : src_s[cur_q];
  assign mem_wdata_o = eng_data;
  assign irq_o       = (done_q && die_q) || (nfb_q && nie_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_AW'(OFF_CTRL): begin
        reg_rdata_o[B_EN]      = en_q;
        reg_rdata_o[B_DONE_IE] = die_q;
        reg_rdata_o[B_NFB_IE]  = nie_q;
      end
      REG_AW'(OFF_INT): begin
        reg_rdata_o[B_I_DONE] = done_q;
        reg_rdata_o[B_I_NFB]  = nfb_q;
      end
      REG_AW'(OFF_STAT): begin
        reg_rdata_o[3:1] = ctl;
        reg_rdata_o[5:4] = buf_st;
        reg_rdata_o[6]   = done_q;
      end
      REG_AW'(OFF_CNT):      reg_rdata_o = REG_DW'(cnt_s[0]);
      REG_AW'(OFF_CNT + 4):  reg_rdata_o = REG_DW'(cnt_s[1]);
      REG_AW'(OFF_ADR):      reg_rdata_o = REG_DW'(src_s[0]);
      REG_AW'(OFF_ADR + 4):  reg_rdata_o = REG_DW'(dst_s[0]);
      REG_AW'(OFF_ADR + 8):  reg_rdata_o = REG_DW'(src_s[1]);
      REG_AW'(OFF_ADR + 12): reg_rdata_o = REG_DW'(dst_s[1]);
      default:               reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dmac_chan_checker.sv
module dmac_chan_checker import dmac_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input ctl_state_e        ctl,
  input buf_state_e        buf_st,
  input logic              done_q,
  input logic              nfb_q,
  input logic [1:0]        valid_s,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);
  p_no_bwc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl != CTL_BWC && buf_st != 2'd3);

  p_word_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  p_read_then_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl == CTL_MEMRD && mem_ack_i && en_q) |=> ctl == CTL_MEMWR);

  p_nfb_continues_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nfb_q) |-> ctl == CTL_MEMRD);

  p_done_in_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (ctl == CTL_STALL && !mem_req_o));

  p_req_needs_en_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> en_q);

  p_flush_slots_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> valid_s == 2'b00);

  p_flush_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |=> ctl == CTL_IDLE);
endmodule

bind m2m_dma_chan dmac_chan_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .ctl       (ctl),
  .buf_st    (buf_st),
  .done_q    (done_q),
  .nfb_q     (nfb_q),
  .valid_s   (valid_s),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .mem_ack_i (mem_ack_i)
);

// File: tb/m2m_dma_chan_bench.sv
module m2m_dma_chan_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_o, mem_we_o, irq_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  m2m_dma_chan u_m2m_dma_chan (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr),
    .reg_addr_i (reg_addr),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack),
    .mem_rdata_i(mem_rdata),
    .irq_o      (irq_o)
  );

  localparam logic [31:0] C_EN = 32'h1, C_ST = 32'h2, C_DIE = 32'h4, C_NIE = 32'h0020_0000;

  int n_run = 0, n_fail = 0;
  logic [31:0] mem [64];
  logic [31:0] wr_log [256];
  int wr_cnt = 0;

  function automatic logic [31:0] init_word(int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0001_0003;
  endfunction

  function automatic logic [31:0] st(int c, int b, int d);
    return 32'((c << 1) | (b << 4) | (d << 6));
  endfunction

  // memory model: ack the same cycle a request is seen
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req_o) begin
      mem_ack = 1'b1;
      if (mem_we_o) begin
        mem[mem_addr_o[7:2]] = mem_wdata_o;
        wr_log[wr_cnt[7:0]] = mem_addr_o;
        wr_cnt++;
      end else mem_rdata = mem[mem_addr_o[7:2]];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(string tag);
    int t = 0;
    while (!irq_o && t < 400) begin @(negedge clk); t++; end
    chk({tag, " irq seen"}, 32'(irq_o), 32'd1);
  endtask

  task automatic wait_done(string tag);
    logic [31:0] s;
    int t = 0;
    rd(8'h0C, s);
    while (!s[6] && t < 400) begin rd(8'h0C, s); t++; end
    chk({tag, " done seen"}, 32'(s[6]), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 64; i++) mem[i] = (i < 32) ? init_word(i) : 32'h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h0C, v); chk("R1 status", v, 32'h0);
    rd(8'h04, v); chk("R1 int", v, 32'h0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 req", 32'(mem_req_o), 0);

    // R3 short count ignored
    wr(8'h10, 32'd2);
    rd(8'h0C, v); chk("R3 short count ignored", v, st(0, 0, 0));

    // R4 slot 1 first, then slot 0
    wr(8'h20, 32'h0B); wr(8'h24, 32'h80); wr(8'h14, 32'd17);
    rd(8'h20, v); chk("R6 src aligned", v, 32'h08);
    rd(8'h14, v); chk("R3 count low bits dropped", v, 32'd16);
    rd(8'h0C, v); chk("R2 one loaded", v, st(0, 1, 0));
    wr(8'h18, 32'h40); wr(8'h1C, 32'hC0); wr(8'h10, 32'd24);
    rd(8'h0C, v); chk("R2 two loaded", v, st(0, 2, 0));
    wr(8'h10, 32'd8);
    rd(8'h10, v); chk("R3 occupied slot ignored", v, 32'd24);

    base = wr_cnt;
    wr(8'h00, C_EN | C_DIE | C_NIE);
    repeat (2) @(negedge clk);
    chk("R5 read req", 32'(mem_req_o && !mem_we_o), 1);
    chk("R4 first slot src", mem_addr_o, 32'h08);

    wait_irq("R7");
    rd(8'h04, v); chk("R7 nfb only", v, 32'h4);
    rd(8'h0C, v); chk("R7 one left", 32'(v[5:4]), 1);
    chk("R2 busy ctl", 32'(v[3:1] == 3'd2 || v[3:1] == 3'd3), 1);
    wr(8'h04, 32'h2);
    chk("R10 nfb cleared irq", 32'(irq_o), 0);
    wait_irq("R8");
    rd(8'h04, v); chk("R8 done only", v, 32'h2);
    rd(8'h0C, v); chk("R8 stall none done", v, st(1, 0, 1));
    rd(8'h10, v); chk("R13 count0 zero", v, 0);
    rd(8'h14, v); chk("R13 count1 zero", v, 0);
    for (int i = 0; i < 4; i++) chk("R6 dst slot1", mem[32 + i], init_word(2 + i));
    for (int i = 0; i < 6; i++) chk("R6 dst slot0", mem[48 + i], init_word(16 + i));
    chk("R6 write count", 32'(wr_cnt - base), 10);
    chk("R4 first write", wr_log[base[7:0]], 32'h80);
    chk("R7 continue other", wr_log[8'(base + 4)], 32'hC0);

    // R10 writing ones keeps, zero clears
    wr(8'h04, 32'h6);
    rd(8'h04, v); chk("R10 ones keep", v, 32'h2);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R10 zero clears", v, 32'h0);
    chk("R10 irq low", 32'(irq_o), 0);

    // R9 loaded slot waits for start
    base = wr_cnt;
    wr(8'h18, 32'h20); wr(8'h1C, 32'h80); wr(8'h10, 32'd8);
    repeat (10) @(negedge clk);
    rd(8'h0C, v); chk("R9 held in stall", v, st(1, 1, 0));
    chk("R9 no writes", 32'(wr_cnt - base), 0);
    wr(8'h00, C_EN | C_ST | C_DIE | C_NIE);
    wait_done("R9");
    chk("R9 word0", mem[32], init_word(8));
    chk("R9 word1", mem[33], init_word(9));

    // R11 interrupt masks
    wr(8'h04, 32'h0);
    wr(8'h00, C_EN);
    wr(8'h18, 32'h0); wr(8'h1C, 32'hF0); wr(8'h10, 32'd4);
    wr(8'h00, C_EN | C_ST);
    wait_done("R11");
    chk("R11 masked done", 32'(irq_o), 0);
    wr(8'h00, C_EN | C_DIE);
    chk("R11 done enabled", 32'(irq_o), 1);
    wr(8'h00, C_EN | C_NIE);
    chk("R11 only nfb enabled", 32'(irq_o), 0);

    // R12 disable mid transfer
    wr(8'h04, 32'h0);
    wr(8'h18, 32'h0); wr(8'h1C, 32'h80); wr(8'h10, 32'd80);
    wr(8'h20, 32'h0); wr(8'h24, 32'h80); wr(8'h14, 32'd80);
    wr(8'h00, C_EN | C_ST);
    repeat (6) @(negedge clk);
    chk("R12 running", 32'(mem_req_o), 1);
    wr(8'h00, 32'h0);
    chk("R12 req dropped", 32'(mem_req_o), 0);
    rd(8'h0C, v); chk("R12 idle none", v, st(0, 0, 0));
    rd(8'h14, v); chk("R12 queued discarded", v, 0);
    wr(8'h00, C_EN);
    base = wr_cnt;
    begin
      int reqs = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req_o) reqs++; end
      chk("R12 no requests after re-enable", 32'(reqs), 0);
    end
    rd(8'h0C, v); chk("R12 stall empty", v, st(1, 0, 0));
    wr(8'h00, 32'h0);

    // sweep of slot length pairs
    for (int n0 = 1; n0 <= 3; n0++) begin
      for (int n1 = 1; n1 <= 3; n1++) begin
        wr(8'h04, 32'h0);
        for (int i = 32; i < 48; i++) mem[i] = 32'h0;
        base = wr_cnt;
        wr(8'h18, 32'h00); wr(8'h1C, 32'h80); wr(8'h10, 32'(4 * n0));
        wr(8'h20, 32'h20); wr(8'h24, 32'hA0); wr(8'h14, 32'(4 * n1));
        wr(8'h00, C_EN | C_ST | C_DIE | C_NIE);
        wait_done("R8 sweep");
        rd(8'h04, v); chk("R7 sweep both ints", v, 32'h6);
        chk("R6 sweep writes", 32'(wr_cnt - base), 32'(n0 + n1));
        chk("R4 sweep order", wr_log[base[7:0]], 32'h80);
        for (int i = 0; i < 4; i++)
          chk("R6 sweep dst0", mem[32 + i], (i < n0) ? init_word(i) : 32'h0);
        for (int i = 0; i < 4; i++)
          chk("R6 sweep dst1", mem[40 + i], (i < n1) ? init_word(8 + i) : 32'h0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule